// File: doc/BRIEF.md
# Interleaved Four-Lane Word Serializer

This block turns a 20-bit parallel word into a one-bit serial stream, sending one bit per clock cycle in frames of 20 cycles that follow each other with no gap. At the frame boundary the word is split across four 5-bit shift registers, called lanes. Each lane takes every fourth bit of the word. A two-level multiplexer tree merges the lanes back into one stream. The first level builds an odd-position stream from lanes 0 and 1 and an even-position stream from lanes 2 and 3. The second level alternates between those two streams. As a result, each lane register advances only once every four cycles, and each first-level select changes only once every two cycles.

A single clock at the serial bit rate drives the whole block. A modulo-20 slot counter produces the load, shift and select enables that would otherwise come from divided clocks. Upstream logic presents a word with a one-cycle valid strobe at any point in the frame. An input latch holds the most recent word until the next frame boundary, and that word is resent for as long as no newer word arrives. A frame-start output marks the cycle in which the first bit of each word is on the line.

Top module: `ser_word_tx`

## Requirements
- R1: The bit at index k of the word (word_in[k], with k from 0 to 19) appears on ser_out in cycle k of its frame. Index 0 goes first, and one bit is sent per clock.
- R2: Lane j (0 to 3) loads word bits 4p + 2*(j mod 2) + (j div 2) for positions p = 0 to 4 at the frame boundary. Every lane then advances one position after every fourth serial cycle.
- R3: frame_start is high for exactly one cycle, in the cycle that carries bit index 0, and it repeats every 20 cycles.
- R4: A strobe during a frame stores the word in the input latch without changing any bit of the frame in progress. The stored word is sent in the next frame.
- R5: A word strobed in the last cycle of a frame, which is the load cycle, is the word sent in the frame that immediately follows.
- R6: When no strobe has arrived since the last load, the previously sent word is sent again unchanged.
- R7: While rst_n is low, ser_out and frame_start are 0 and the lanes and the latch are cleared. After release, ser_out stays 0 and frame_start stays low for 19 cycles. The first frame starts in the 20th cycle and carries the latched word, which is all zeros if no word was strobed.
- R8: When several strobes land in one frame, the last one before the boundary is the word sent next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_in | input | 20 | Parallel word; bit 0 is sent first |
| word_vld | input | 1 | One-cycle strobe that captures word_in |
| ser_out | output | 1 | Serial data bit |
| frame_start | output | 1 | High while bit 0 of a word is on ser_out |

## Verification
The bench builds the block with its default 20-bit word, which gives four lanes of five positions and a 20-slot frame. At this size every lane shift, every first-level select phase and the lane-to-bit mapping are visible at ser_out within a single frame. Because the frame is short, strobes can be placed on every slot, including the load cycle, many hundreds of times within the run. A mid-run reset brings the post-release silence and the first-frame timing within reach a second time.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int TREE_LANES = 4;

  // Word bit index held by position pos of lane 'lane'.
  // Lanes 0/1 feed the even-index (first, third, ...) stream, lanes 2/3 the odd-index one.
  function automatic int word_bit_of(input int lane, input int pos);
    return pos * TREE_LANES + (lane % 2) * 2 + (lane / 2);
  endfunction
endpackage

// File: rtl/ser_tx_slot_ctr.sv
module ser_tx_slot_ctr #(
  parameter int SLOTS = 20,
  localparam int CW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] slot,
  output logic          load_en,
  output logic          shift_en,
  output logic          sel_pair,
  output logic          sel_bit
);
  localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            slot <= '0;
    else if (slot == LAST) slot <= '0;
    else                   slot <= slot + 1'b1;
  end

  assign load_en  = (slot == LAST);
  assign shift_en = (slot[1:0] == 2'b11) && !load_en;
  assign sel_pair = slot[1];
  assign sel_bit  = slot[0];

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == LAST) |=> (slot == '0));

  p_single_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !load_en);
endmodule

// File: rtl/ser_tx_lane.sv
module ser_tx_lane #(
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [DEPTH-1:0] load_val,
  input  logic             shift_en,
  output logic             head
);
  logic [DEPTH-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (load_en)  q <= load_val;
    else if (shift_en) q <= {1'b0, q[DEPTH-1:1]};
  end

  assign head = q[0];

  p_lane_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (q == $past(load_val)));

  p_lane_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en) |=> (q == {1'b0, $past(q[DEPTH-1:1])}));

  p_lane_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !load_en) |=> $stable(q));
endmodule

// File: rtl/ser_tx_mux_tree.sv
module ser_tx_mux_tree (
  input  logic [3:0] heads,
  input  logic       sel_pair,
  input  logic       sel_bit,
  output logic       ser
);
  logic first_stream;
  logic second_stream;

  always_comb begin
    first_stream  = sel_pair ? heads[1] : heads[0];
    second_stream = sel_pair ? heads[3] : heads[2];
    ser           = sel_bit ? second_stream : first_stream;
  end
endmodule

// File: rtl/ser_word_tx.sv
module ser_word_tx #(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_in,
  input  logic              word_vld,
  output logic              ser_out,
  output logic              frame_start
);
  import ser_tx_pkg::*;

  localparam int LANE_D = WORD_W / TREE_LANES;
  localparam int CW     = $clog2(WORD_W);

  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] load_word;
  logic              primed;
  logic [CW-1:0]     slot;
  logic              load_en;
  logic              shift_en;
  logic              sel_pair;
  logic              sel_bit;
  logic [3:0]        heads;
  logic [LANE_D-1:0] lane_load [TREE_LANES];

  // Input latch: newest strobed word waits here for the boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= '0;
    else if (word_vld) hold_q <= word_in;
  end

  // A strobe in the load cycle goes straight into the lanes.
  assign load_word = word_vld ? word_in : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       primed <= 1'b0;
    else if (load_en) primed <= 1'b1;
  end

  ser_tx_slot_ctr #(.SLOTS(WORD_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot     (slot),
    .load_en  (load_en),
    .shift_en (shift_en),
    .sel_pair (sel_pair),
    .sel_bit  (sel_bit)
  );

  for (genvar l = 0; l < TREE_LANES; l++) begin : g_lane
    for (genvar p = 0; p < LANE_D; p++) begin : g_pos
      assign lane_load[l][p] = load_word[word_bit_of(l, p)];
    end
    ser_tx_lane #(.DEPTH(LANE_D)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (load_en),
      .load_val (lane_load[l]),
      .shift_en (shift_en),
      .head     (heads[l])
    );
  end

  ser_tx_mux_tree u_tree (
    .heads    (heads),
    .sel_pair (sel_pair),
    .sel_bit  (sel_bit),
    .ser      (ser_out)
  );

  assign frame_start = primed && (slot == '0);

  p_hold_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> (hold_q == $past(word_in)));

  p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |=> $stable(hold_q));

  p_first_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (ser_out == $past(load_word[0])));

  p_fs_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> (!ser_out && !frame_start));
endmodule

// File: tb/sim_ser_word_tx.sv
module sim_ser_word_tx;
  localparam int W = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] word_in = '0;
  logic         word_vld = 1'b0;
  logic         ser_out;
  logic         frame_start;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] ref_hold = '0;
  logic [W-1:0] frame_word = '0;
  int bitidx = -1;
  int samp_n = 0;
  int mode = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  ser_word_tx #(.WORD_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .word_in(word_in), .word_vld(word_vld),
    .ser_out(ser_out), .frame_start(frame_start)
  );

  task automatic chk(input string t, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0b expected=%0b", t, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd_word();
    return W'($urandom);
  endfunction

  // One cycle: sample at the falling edge, check, then drive the next inputs.
  task automatic step();
    logic v;
    logic [W-1:0] w;
    @(negedge clk);
    samp_n++;
    if (frame_start) begin
      if (bitidx < 0) chk("R7", samp_n == 20, 1'b1, "first frame_start at 20th cycle");
      else chk("R3", bitidx == W - 1, 1'b1, "frame_start spacing of 20");
      frame_word = ref_hold;
      bitidx = 0;
    end else if (bitidx >= 0) begin
      bitidx++;
      if (bitidx > W - 1) begin
        chk("R3", 1'b0, 1'b1, "frame_start missing after 20 cycles");
        bitidx = W - 1;
      end
    end
    if (bitidx >= 0) chk(tag, ser_out, frame_word[bitidx], $sformatf("bit %0d", bitidx));
    else chk("R7", ser_out, 1'b0, "ser_out before first frame");
    v = 1'b0;
    w = '0;
    case (mode)
      1: begin v = ($urandom % 6) == 0; w = rnd_word(); end
      2: begin
        if (bitidx == 7 || bitidx == W - 1) begin v = 1'b1; w = rnd_word(); end
      end
      3: begin
        if (bitidx == 2 || bitidx == 9 || bitidx == 15) begin v = 1'b1; w = rnd_word(); end
      end
      default: ;
    endcase
    word_vld = v;
    word_in  = w;
    if (v) ref_hold = w;
  endtask

  task automatic reset_phase();
    @(negedge clk);
    rst_n = 1'b0;
    word_vld = 1'b0;
    word_in = '0;
    #1;
    chk("R7", ser_out, 1'b0, "ser_out in reset");
    chk("R7", frame_start, 1'b0, "frame_start in reset");
    repeat (3) begin
      @(negedge clk);
      chk("R7", ser_out, 1'b0, "ser_out in reset");
      chk("R7", frame_start, 1'b0, "frame_start in reset");
    end
    ref_hold = '0;
    bitidx = -1;
    samp_n = 0;
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd2024));
    reset_phase();
    // R7: no word strobed, so the first frame carries zeros
    mode = 0; tag = "R7";
    repeat (45) step();
    // R1, R4, R8: random strobes anywhere in the frame
    mode = 1; tag = "R1";
    repeat (2000) step();
    // R6: one frame with a word, then nothing new
    mode = 3; tag = "R8";
    repeat (20) step();
    mode = 0; tag = "R6";
    repeat (100) step();
    // R5: strobes mid-frame and exactly in the load cycle
    mode = 2; tag = "R5";
    repeat (400) step();
    // R8: three strobes per frame, last one wins
    mode = 3; tag = "R8";
    repeat (300) step();
    // R7 again: reset in the middle of a frame
    mode = 0; tag = "R7";
    repeat (7) step();
    reset_phase();
    repeat (30) step();
    mode = 1; tag = "R4";
    repeat (500) step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule